// File: doc/BRIEF.md
# Multicarrier PWM Gate Generator

This block drives the nine power switches of a single-phase nine-level inverter. The inverter has a five-switch stage that builds the voltage magnitude and a four-switch H-bridge that applies polarity. Each clock, the block advances a sine reference read from a quarter-wave table by a phase accumulator. It compares the reference magnitude against four level-shifted triangular carriers, one per magnitude band, and so picks a level from 0 to 4. It then decodes that level and the reference sign into registered gate outputs.

The carrier of the lowest band (levels 0 to 1) runs at an integer multiple of the base carrier rate. At low output the waveform therefore drops to zero more often, and each zero gives the second capacitor a chance to recharge. The upper bands stay at the base rate to keep switching loss down.

Modulation depth, reference frequency, carrier frequency and the multiple can change while the block runs. New values are taken only at a base-carrier trough. A sign change in the reference always passes through a zero-level clock, so the two bridge diagonals never swap directly.

Top module: `mlpwm_gate_gen`

## Requirements
- R1: A clock edge with `rst` high sets `lv_gate` to 00000 and `br_gate` to 0011, where `br_gate` bit0=H1, bit1=H2, bit2=H3 and bit3=H4. The same edge clears both phase accumulators and loads the four held settings from the current inputs.
- R2: The reference phase is 32 bits wide and grows by the held `ref_step` on every clock. Bit 31 set means the negative half. The table index is phase bits 29:24, replaced by 63 minus that index when bit 30 is set. The sample is floor(16*x*32767 / (327680 - 4*x)), with n = 2*index+1 and x = n*(256-n).
- R3: The scaled magnitude is floor(sample * held `mod_index` / 2^14). A `mod_index` of 65535 therefore spans four bands of 32768 each.
- R4: The base carrier phase is 16 bits wide and grows by the held `car_step` on every clock. Its ramp is the phase itself when below 32768, otherwise 65535 minus the phase. For bands k = 1, 2, 3 the carrier is 32768*k plus this ramp.
- R5: The band-0 carrier applies the same ramp rule to (base phase * M) mod 65536. M is the held `zero_band_mult`, where 0 reads as 1 and any value above 8 reads as 8.
- R6: The raw level is the number of the four carriers that lie strictly below the scaled magnitude, giving a value from 0 to 4.
- R7: One clock after the phase state it comes from, `lv_gate` (bit0=S1 … bit4=S5, written bit4..bit0) shows:
  - 01001 for levels 0 and 2;
  - 10100 for level 1;
  - 00110 for level 3;
  - 00101 for level 4.
- R8: At a nonzero level, `br_gate` is 1001 for positive polarity and 0110 for negative polarity. At level 0, `br_gate` is 0011 and `lv_gate` carries the level-0 pattern.
- R9: A polarity register, positive after reset, takes the reference sign only in a clock whose effective level is 0. While the sign differs from the polarity, the effective level is forced to 0, so `br_gate` never moves directly between 1001 and 0110.
- R10: `mod_index`, `ref_step`, `car_step` and `zero_band_mult` are taken only on an edge where the base carrier addition carries out of 16 bits, or where `rst` is high. Changes at any other time have no effect until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_index | input | 16 | Modulation depth, 65535 is about 1.0 |
| ref_step | input | 32 | Reference phase increment per clock |
| car_step | input | 16 | Base carrier phase increment per clock |
| zero_band_mult | input | 4 | Band-0 carrier rate multiple, 1 to 8 |
| lv_gate | output | 5 | Level-stage gates, bit0=S1 … bit4=S5 |
| br_gate | output | 4 | H-bridge gates, bit0=H1 … bit3=H4 |

## Verification
A wrong reference or carrier phase shows in the gate vector one clock after the state that caused it, but only once a comparator decision flips. A small phase error can therefore stay hidden for several carrier ramps, while a wrong quadrant or sign shows within one band crossing. A setting taken at the wrong moment moves the switching instants for the rest of the carrier period. A wrong polarity register shows as the wrong bridge diagonal at the next nonzero level, or as a missing forced zero at a sign change. The bench compares all nine gates on every clock against a behavioural model, and counts the levels and polarities it has seen, so these divergences show up within cycles.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

   localparam int NUM_LV_SW = 5;
   localparam int NUM_BR_SW = 4;

   typedef logic [2:0] level_t;

   localparam logic [NUM_LV_SW-1:0] LV_RESET = 5'b00000;
   localparam logic [NUM_BR_SW-1:0] BR_ZERO  = 4'b0011;
   localparam logic [NUM_BR_SW-1:0] BR_POS   = 4'b1001;
   localparam logic [NUM_BR_SW-1:0] BR_NEG   = 4'b0110;

   // level-stage switch pattern, bit0 = first switch
   function automatic logic [NUM_LV_SW-1:0] lv_pattern(input level_t lvl);
      case (lvl)
         3'd0:    return 5'b01001;
         3'd1:    return 5'b10100;
         3'd2:    return 5'b01001;
         3'd3:    return 5'b00110;
         3'd4:    return 5'b00101;
         default: return 5'b01001;
      endcase
   endfunction

endpackage

// File: rtl/mlpwm_ref_gen.sv
module mlpwm_ref_gen #(
   parameter int PH_W   = 32,
   parameter int LUT_AW = 6,
   parameter int SMP_W  = 16,
   parameter int MI_W   = 16,
   parameter int MAG_W  = 17
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PH_W-1:0]   step,
   input  logic [MI_W-1:0]   mod_idx,
   output logic [MAG_W-1:0]  mag,
   output logic              neg
);

   localparam int QDEPTH = 2 ** LUT_AW;
   localparam int HALF_N = 2 ** (LUT_AW + 2);
   localparam int AMP    = 2 ** (SMP_W - 1) - 1;
   localparam int PROD_W = SMP_W - 1 + MI_W;
   localparam int SH     = PROD_W - MAG_W;

   initial begin
      AST_CFG_PROD: assert (PROD_W >= MAG_W) else $error("product narrower than magnitude");
      AST_CFG_PHASE: assert (PH_W >= LUT_AW + 2) else $error("phase too narrow for table");
      AST_CFG_RANGE: assert (2 * LUT_AW + SMP_W + 5 < 63) else $error("table arithmetic overflows");
   end

   function automatic logic [SMP_W-2:0] quarter_sine(input int j);
      longint n, x, num, den, v;
      n   = 2 * longint'(j) + 1;
      x   = n * (longint'(HALF_N) - n);
      num = 16 * x * longint'(AMP);
      den = 5 * longint'(HALF_N) * longint'(HALF_N) - 4 * x;
      v   = num / den;
      return v[SMP_W-2:0];
   endfunction

   logic [SMP_W-2:0] rom [QDEPTH];

   for (genvar j = 0; j < QDEPTH; j++) begin : g_rom
      assign rom[j] = quarter_sine(j);
   end

   logic [PH_W-1:0]   ph;
   logic [LUT_AW-1:0] idx;
   logic [SMP_W-2:0]  sample;
   logic [PROD_W-1:0] prod;

   always_ff @(posedge clk) begin
      if (rst) ph <= '0;
      else     ph <= ph + step;
   end

   assign idx    = ph[PH_W-2] ? ~ph[PH_W-3 -: LUT_AW] : ph[PH_W-3 -: LUT_AW];
   assign sample = rom[idx];
   assign prod   = PROD_W'(sample) * PROD_W'(mod_idx);
   assign mag    = MAG_W'(prod >> SH);
   assign neg    = ph[PH_W-1];

endmodule

// File: rtl/mlpwm_carrier_gen.sv
module mlpwm_carrier_gen #(
   parameter int CAR_W          = 16,
   parameter int MULT_W         = 4,
   parameter bit FAST_ZERO_BAND = 1'b1,
   localparam int TRI_W         = CAR_W - 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CAR_W-1:0]  step,
   input  logic [MULT_W-1:0] mult,
   output logic [TRI_W-1:0]  ramp_base,
   output logic [TRI_W-1:0]  ramp_zero,
   output logic              trough
);

   function automatic logic [TRI_W-1:0] to_ramp(input logic [CAR_W-1:0] p);
      return p[CAR_W-1] ? ~p[TRI_W-1:0] : p[TRI_W-1:0];
   endfunction

   logic [CAR_W-1:0] ph;
   logic [CAR_W-1:0] nxt;
   logic             carry;

   assign {carry, nxt} = {1'b0, ph} + {1'b0, step};
   assign trough       = carry;

   always_ff @(posedge clk) begin
      if (rst) ph <= '0;
      else     ph <= nxt;
   end

   assign ramp_base = to_ramp(ph);

   if (FAST_ZERO_BAND) begin : g_fast
      logic [CAR_W-1:0] fast_ph;
      assign fast_ph   = ph * CAR_W'(mult);
      assign ramp_zero = to_ramp(fast_ph);
   end else begin : g_slow
      assign ramp_zero = to_ramp(ph);
   end

   AST_WRAP_SMALL: assert property (@(posedge clk) disable iff (rst)
      trough |=> (ph < $past(step))) else $error("wrap left phase too large"); // R4

endmodule

// File: rtl/mlpwm_level_cmp.sv
module mlpwm_level_cmp
   import mlpwm_pkg::*;
#(
   parameter int NUM_BANDS = 4,
   parameter int TRI_W     = 15,
   localparam int KW       = $clog2(NUM_BANDS),
   localparam int MAG_W    = TRI_W + KW
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [MAG_W-1:0] mag,
   input  logic [TRI_W-1:0] ramp_zero,
   input  logic [TRI_W-1:0] ramp_base,
   output level_t           level
);

   logic [NUM_BANDS-1:0] cmp;

   for (genvar k = 0; k < NUM_BANDS; k++) begin : g_band
      logic [TRI_W-1:0] ramp_sel;
      if (k == 0) begin : g_lo
         assign ramp_sel = ramp_zero;
      end else begin : g_hi
         assign ramp_sel = ramp_base;
      end
      assign cmp[k] = mag > {KW'(k), ramp_sel};

      if (k > 0) begin : g_chk
         AST_THERMO: assert property (@(posedge clk) disable iff (rst)
            cmp[k] |-> cmp[k-1]) else $error("band compare not thermometer"); // R6
      end
   end

   always_comb begin
      level = '0;
      for (int k = 0; k < NUM_BANDS; k++) level = level + level_t'(cmp[k]);
   end

endmodule

// File: rtl/mlpwm_gate_dec.sv
module mlpwm_gate_dec
   import mlpwm_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst,
   input  level_t               level,
   input  logic                 neg,
   output logic [NUM_LV_SW-1:0] lv_gate,
   output logic [NUM_BR_SW-1:0] br_gate
);

   logic   pol_q;
   level_t lvl_eff;

   assign lvl_eff = (neg != pol_q) ? level_t'(0) : level;

   always_ff @(posedge clk) begin
      if (rst) begin
         pol_q   <= 1'b0;
         lv_gate <= LV_RESET;
         br_gate <= BR_ZERO;
      end else begin
         if (lvl_eff == level_t'(0)) pol_q <= neg;
         lv_gate <= lv_pattern(lvl_eff);
         if (lvl_eff == level_t'(0)) br_gate <= BR_ZERO;
         else if (pol_q)             br_gate <= BR_NEG;
         else                        br_gate <= BR_POS;
      end
   end

   AST_LEG_EXCL: assert property (@(posedge clk) disable iff (rst)
      !((br_gate[0] && br_gate[2]) || (br_gate[1] && br_gate[3]))) else $error("leg shoot-through"); // R8

   AST_NO_FLIP_POS: assert property (@(posedge clk) disable iff (rst)
      (br_gate == BR_POS) |=> (br_gate != BR_NEG)) else $error("direct reversal"); // R9

   AST_NO_FLIP_NEG: assert property (@(posedge clk) disable iff (rst)
      (br_gate == BR_NEG) |=> (br_gate != BR_POS)) else $error("direct reversal"); // R9

   AST_POL_HOLD: assert property (@(posedge clk) disable iff (rst)
      (lvl_eff != level_t'(0)) |=> (pol_q == $past(pol_q))) else $error("polarity moved at nonzero level"); // R9

   AST_ZERO_LV: assert property (@(posedge clk) disable iff (rst)
      (br_gate == BR_ZERO && lv_gate != LV_RESET) |-> (lv_gate == lv_pattern(level_t'(0))))
      else $error("zero level with wrong stage pattern"); // R8

endmodule

// File: rtl/mlpwm_gate_gen.sv
module mlpwm_gate_gen
   import mlpwm_pkg::*;
#(
   parameter int LEVELS         = 9,
   parameter int PH_W           = 32,
   parameter int LUT_AW         = 6,
   parameter int SMP_W          = 16,
   parameter int MI_W           = 16,
   parameter int CAR_W          = 16,
   parameter int MULT_W         = 4,
   parameter int MULT_MAX       = 8,
   parameter bit FAST_ZERO_BAND = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [MI_W-1:0]      mod_index,
   input  logic [PH_W-1:0]      ref_step,
   input  logic [CAR_W-1:0]     car_step,
   input  logic [MULT_W-1:0]    zero_band_mult,
   output logic [NUM_LV_SW-1:0] lv_gate,
   output logic [NUM_BR_SW-1:0] br_gate
);

   localparam int BANDS = (LEVELS - 1) / 2;
   localparam int TRI_W = CAR_W - 1;
   localparam int MAG_W = TRI_W + $clog2(BANDS);

   initial begin
      AST_CFG_LEVELS: assert (LEVELS == 9) else $error("decoder supports nine levels only");
      AST_CFG_MULT: assert (MULT_MAX >= 1 && MULT_MAX < 2 ** MULT_W) else $error("multiple range");
      AST_CFG_CAR: assert (CAR_W >= 4) else $error("carrier phase too narrow");
   end

   logic [MI_W-1:0]   mi_q;
   logic [PH_W-1:0]   rs_q;
   logic [CAR_W-1:0]  cs_q;
   logic [MULT_W-1:0] mult_q;
   logic [MULT_W-1:0] mult_clamped;
   logic              trough;
   logic [TRI_W-1:0]  ramp_base;
   logic [TRI_W-1:0]  ramp_zero;
   logic [MAG_W-1:0]  mag;
   logic              neg;
   level_t            level;

   always_comb begin
      if (zero_band_mult == '0)                     mult_clamped = MULT_W'(1);
      else if (zero_band_mult > MULT_W'(MULT_MAX)) mult_clamped = MULT_W'(MULT_MAX);
      else                                          mult_clamped = zero_band_mult;
   end

   always_ff @(posedge clk) begin
      if (rst || trough) begin
         mi_q   <= mod_index;
         rs_q   <= ref_step;
         cs_q   <= car_step;
         mult_q <= mult_clamped;
      end
   end

   mlpwm_ref_gen #(
      .PH_W(PH_W), .LUT_AW(LUT_AW), .SMP_W(SMP_W), .MI_W(MI_W), .MAG_W(MAG_W)
   ) u_ref (
      .clk(clk), .rst(rst), .step(rs_q), .mod_idx(mi_q), .mag(mag), .neg(neg)
   );

   mlpwm_carrier_gen #(
      .CAR_W(CAR_W), .MULT_W(MULT_W), .FAST_ZERO_BAND(FAST_ZERO_BAND)
   ) u_car (
      .clk(clk), .rst(rst), .step(cs_q), .mult(mult_q),
      .ramp_base(ramp_base), .ramp_zero(ramp_zero), .trough(trough)
   );

   mlpwm_level_cmp #(
      .NUM_BANDS(BANDS), .TRI_W(TRI_W)
   ) u_cmp (
      .clk(clk), .rst(rst), .mag(mag), .ramp_zero(ramp_zero), .ramp_base(ramp_base), .level(level)
   );

   mlpwm_gate_dec u_dec (
      .clk(clk), .rst(rst), .level(level), .neg(neg), .lv_gate(lv_gate), .br_gate(br_gate)
   );

   AST_LOAD_AT_TROUGH: assert property (@(posedge clk) disable iff (rst)
      !trough |=> ($stable(mi_q) && $stable(rs_q) && $stable(cs_q) && $stable(mult_q)))
      else $error("settings changed away from trough"); // R10

   AST_MULT_RANGE: assert property (@(posedge clk) disable iff (rst)
      (mult_q != '0) && (mult_q <= MULT_W'(MULT_MAX))) else $error("multiple out of range"); // R5

endmodule

// File: tb/mlpwm_gate_gen_tb_top.sv
module mlpwm_gate_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] mod_index;
   logic [31:0] ref_step;
   logic [15:0] car_step;
   logic [3:0]  zb_mult;
   logic [4:0]  lv_gate;
   logic [3:0]  br_gate;

   mlpwm_gate_gen dut_i (
      .clk(clk), .rst(rst), .mod_index(mod_index), .ref_step(ref_step),
      .car_step(car_step), .zero_band_mult(zb_mult), .lv_gate(lv_gate), .br_gate(br_gate)
   );

   always #4 clk = ~clk;

   int    n_chk  = 0;
   int    n_fail = 0;
   string tag    = "R1";
   bit    cmp_en = 1'b0;
   bit    done   = 1'b0;

   longint     m_ref = 0, m_car = 0, m_rs = 0, m_cs = 0, m_mult = 1, m_mi = 0;
   bit         m_pol = 1'b0;
   logic [4:0] e_lv = 5'b00000;
   logic [3:0] e_br = 4'b0011;
   int         forced = 0, pos_seen = 0, neg_seen = 0;
   int         lvl_seen [0:4] = '{default: 0};

   function automatic longint ref_sample(longint ph);
      longint idx, n, x;
      idx = (ph >> 24) & 63;
      if (((ph >> 30) & 1) == 1) idx = 63 - idx;
      n = 2 * idx + 1;
      x = n * (256 - n);
      return (16 * x * 32767) / (327680 - 4 * x);
   endfunction

   function automatic longint ramp_of(longint ph);
      return (ph >= 32768) ? (65535 - ph) : ph;
   endfunction

   function automatic logic [4:0] pattern_of(int lvl);
      case (lvl)
         1:       return 5'b10100;
         3:       return 5'b00110;
         4:       return 5'b00101;
         default: return 5'b01001;
      endcase
   endfunction

   task automatic load_shadow();
      m_rs = longint'(ref_step);
      m_cs = longint'(car_step);
      m_mi = longint'(mod_index);
      if (zb_mult == 4'd0)     m_mult = 1;
      else if (zb_mult > 4'd8) m_mult = 8;
      else                     m_mult = longint'(zb_mult);
   endtask

   // behavioural reference, advanced at each rising edge
   always @(posedge clk) begin : model
      longint mag, rb, rz, nc;
      int     lvl;
      bit     sgn;
      if (rst) begin
         m_ref = 0; m_car = 0; load_shadow();
         m_pol = 1'b0; e_lv = 5'b00000; e_br = 4'b0011;
      end else begin
         sgn = (((m_ref >> 31) & 1) == 1);
         mag = (ref_sample(m_ref) * m_mi) >> 14;
         rb  = ramp_of(m_car);
         rz  = ramp_of((m_car * m_mult) & 65535);
         lvl = 0;
         if (mag > rz)          lvl++;
         if (mag > 32768 + rb)  lvl++;
         if (mag > 65536 + rb)  lvl++;
         if (mag > 98304 + rb)  lvl++;
         if (sgn != m_pol) begin
            if (lvl != 0) forced++;
            lvl = 0;
         end
         if (lvl == 0) m_pol = sgn;
         lvl_seen[lvl]++;
         e_lv = pattern_of(lvl);
         if (lvl == 0)   e_br = 4'b0011;
         else if (m_pol) e_br = 4'b0110;
         else            e_br = 4'b1001;
         if (e_br == 4'b1001) pos_seen++;
         if (e_br == 4'b0110) neg_seen++;
         m_ref = (m_ref + m_rs) & 64'hFFFF_FFFF;
         nc = m_car + m_cs;
         if (nc >= 65536) load_shadow();
         m_car = nc & 65535;
      end
   end

   always @(negedge clk) begin
      if (cmp_en && !done) begin
         n_chk++;
         if (lv_gate !== e_lv || br_gate !== e_br) begin
            n_fail++;
            $display("FAIL %s gates: actual lv=%b br=%b expected lv=%b br=%b", tag, lv_gate, br_gate, e_lv, e_br);
         end
      end
   end

   task automatic check_val(string req, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_true(string req, string what, bit ok, longint act);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected nonzero", req, what, act);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   task automatic run(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      mod_index = 16'd62259; ref_step = 32'd524288; car_step = 16'd256; zb_mult = 4'd4;
      repeat (3) @(negedge clk);
      cmp_en = 1'b1;
      check_val("R1", "lv_gate in reset", longint'(lv_gate), 0);
      check_val("R1", "br_gate in reset", longint'(br_gate), 3);
      // main modulation at depth 0.95
      tag = "R2"; rst = 1'b0; run(9000);
      // mid-period change of depth and frequency, taken at the next trough only
      tag = "R10"; mod_index = 16'd39322; ref_step = 32'd1048576; run(37);
      zb_mult = 4'd2; run(9000);
      // multiple clamping
      tag = "R5"; zb_mult = 4'd0; run(6000);
      zb_mult = 4'd15; run(6000);
      zb_mult = 4'd8; run(3000);
      // carrier step that is not a power of two
      tag = "R4"; car_step = 16'd1000; zb_mult = 4'd3; run(6000);
      // full-scale depth, then zero depth
      tag = "R3"; mod_index = 16'd65535; ref_step = 32'd524288; car_step = 16'd256; run(9000);
      mod_index = 16'd0; run(3000);
      // sign alternating with large magnitude forces zero-level clocks
      tag = "R9"; mod_index = 16'd65535; ref_step = 32'h7000_0000; run(3000);
      check_true("R9", "forced zero clocks", forced > 0, forced);
      // reset in the middle of operation
      tag = "R1"; rst = 1'b1; run(2);
      check_val("R1", "lv_gate after mid-run reset", longint'(lv_gate), 0);
      check_val("R1", "br_gate after mid-run reset", longint'(br_gate), 3);
      mod_index = 16'd62259; ref_step = 32'd524288; car_step = 16'd256; zb_mult = 4'd4;
      run(1);
      tag = "R6"; rst = 1'b0; run(9000);
      check_true("R6", "level 4 reached", lvl_seen[4] > 0, lvl_seen[4]);
      for (int l = 0; l < 5; l++) check_true("R7", $sformatf("level %0d seen", l), lvl_seen[l] > 0, lvl_seen[l]);
      check_true("R8", "positive diagonal seen", pos_seen > 0, pos_seen);
      check_true("R8", "negative diagonal seen", neg_seen > 0, neg_seen);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule